// File: doc/BRIEF.md
# Chainable Up/Down Timer Pair

Two 16-bit timer/counters share one register write port. Each timer has a control word and a count register that can be loaded at any time. A timer can count ticks from an internal count slot or edges on its own external clock pin. It counts up or down through a power-of-two prescaler. Each timer pulses a wrap flag when it rolls over.

The upper timer has two extra features. It can be chained to the lower timer to form one 32-bit time base, and it can be cleared by an edge on an output-event input. While chained, the upper half steps only when the lower half wraps. The lower timer's direction bit then sets the direction of both halves.

Writes use `wr_addr` to pick a target: 0 is the lower control word, 1 the upper control word, 2 the lower count and 3 the upper count. A control write takes effect from the next cycle.

Top module: `tpr_timer_pair`

## Requirements
- R1: After a synchronous reset, both control words, both counts and both wrap flags are zero, so neither timer counts.
- R2: Control readback shows bits 15:10 as zero for both timers. For the lower timer, bits 7:5 also read as zero. Every other bit reads back as written.
- R3: While control bit 9 (enable) is 0, a timer's count does not change except through a count write.
- R4: Control bit 8 sets direction: 1 counts up and 0 counts down. In internal mode (bits 4:3 = 00) with divide-by-1, an enabled timer steps once in every cycle where its `slot_tick` bit is high.
- R5: Control bits 2:0 = n (0 to 6) select divide by 2^n: the timer steps on every 2^n-th qualified event. Code 7 acts as divide by 1. A write to the control word restarts the prescaler phase.
- R6: Bits 4:3 select the external pin edges that are counted: 01 falling, 10 rising, 11 both. A pin change shows in the count on the third rising clock edge after it, provided the slot tick is high. An edge seen while the slot tick is low is held pending and counts at the next slot tick.
- R7: A wrap flag is high for exactly one cycle, in the cycle its count rolls over. Rolling over means 0xFFFF to 0 when counting up, or 0 to 0xFFFF when counting down.
- R8: When upper control bit 7 is set, the upper count steps once per lower wrap. The lower timer's bit 8 gives the direction of both halves. The upper timer's own clock and prescale settings are ignored, but its enable bit still gates it.
- R9: Upper control bits 6:5 clear the upper count on an `evt_in` edge. 01 clears on a falling edge, 10 on a rising edge, 11 on either edge, and 00 never. The clear takes effect on the clock edge that first samples the new `evt_in` level.
- R10: A count write loads the value on the next clock edge. It takes priority over counting and over an event clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: 0 lower control, 1 upper control, 2 lower count, 3 upper count |
| wr_data | input | 16 | Write data |
| ext_clk | input | 2 | External clock pins, bit 0 lower timer, bit 1 upper timer |
| evt_in | input | 1 | Output-event level whose edges can clear the upper timer |
| slot_tick | input | 2 | Per-timer count slot qualifier |
| ctl_lo_q | output | 16 | Lower control word readback |
| ctl_hi_q | output | 16 | Upper control word readback |
| cnt_lo | output | CNT_W | Lower count |
| cnt_hi | output | CNT_W | Upper count |
| wrap_lo | output | 1 | Lower wrap pulse |
| wrap_hi | output | 1 | Upper wrap pulse |

## Verification
The bench builds the block with the default 16-bit count width and the full 6-bit prescaler counter, so every divide code from 1 to 64, plus the reserved code, is in play.

Random count writes favour values next to 0 and 0xFFFF. This puts lower wraps, chained upper steps and upper wraps within a few cycles of each write, instead of 65536 steps away.

Random control words and random toggling of the pins, the slot ticks and `evt_in` exercise every mix of clock source, event-clear mode, chaining and direction against a cycle model in the bench.

// File: rtl/tpr_pkg.sv
package tpr_pkg;

    localparam int CTL_W  = 16;
    localparam int PRE_W  = 6;
    localparam int NTMR   = 2;

    typedef struct packed {
        logic [5:0] rsvd;
        logic       en;
        logic       up;
        logic       chain;
        logic [1:0] evt_mode;
        logic [1:0] src;
        logic [2:0] div;
    } tmr_ctl_t;

    typedef enum logic [1:0] {
        SRC_TICK = 2'b00,
        SRC_FALL = 2'b01,
        SRC_RISE = 2'b10,
        SRC_BOTH = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        WA_CTL_LO = 2'd0,
        WA_CTL_HI = 2'd1,
        WA_CNT_LO = 2'd2,
        WA_CNT_HI = 2'd3
    } wr_addr_e;

    // Strip bits that are reserved for the given timer position.
    function automatic tmr_ctl_t ctl_filter(input logic [CTL_W-1:0] d, input logic upper);
        tmr_ctl_t c;
        c      = tmr_ctl_t'(d);
        c.rsvd = '0;
        if (!upper) begin
            c.chain    = 1'b0;
            c.evt_mode = 2'b00;
        end
        return c;
    endfunction

    // Low-bit mask of the prescaler counter for a divide code; code 7 acts as 1.
    function automatic logic [PRE_W-1:0] div_mask(input logic [2:0] code);
        logic [PRE_W:0] t;
        if (code == 3'd7) return '0;
        t = (PRE_W+1)'(1) << code;
        return PRE_W'(t - (PRE_W+1)'(1));
    endfunction

endpackage

// File: rtl/tpr_step_gen.sv
module tpr_step_gen
    import tpr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tmr_ctl_t ctl,
    input  logic     ctl_wr,
    input  logic     pin,
    input  logic     slot,
    output logic     step
);

    logic             s1, s2, s3;
    logic             pend;
    logic [PRE_W-1:0] pre;
    logic             rise, fall, edge_hit, ext, qual;
    logic [PRE_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 & ~s3;
    assign fall = ~s2 & s3;
    assign ext  = (src_e'(ctl.src) != SRC_TICK);

    always_comb begin
        case (src_e'(ctl.src))
            SRC_TICK: edge_hit = 1'b1;
            SRC_FALL: edge_hit = fall;
            SRC_RISE: edge_hit = rise;
            default:  edge_hit = rise | fall;
        endcase
    end

    assign qual = ctl.en && slot && (pend || edge_hit);
    assign mask = div_mask(ctl.div);
    assign step = qual && ((pre & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || ctl_wr) begin
            pre  <= '0;
            pend <= 1'b0;
        end else begin
            if (qual) pre <= pre + 1'b1;
            pend <= (ctl.en && ext) ? ((pend | edge_hit) & ~slot) : 1'b0;
        end
    end

    // R5
    pre_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !ctl_wr && ctl.div != 3'd0 && ctl.div != 3'd7) |=> !step);

endmodule

// File: rtl/tpr_counter.sv
module tpr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clr,
    input  logic         step,
    input  logic         up,
    output logic [W-1:0] cnt,
    output logic         bound,
    output logic         wrap
);

    assign bound = up ? (&cnt) : (~|cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            wrap <= 1'b0;
        end else begin
            wrap <= 1'b0;
            if (load) begin
                cnt <= load_val;
            end else if (clr) begin
                cnt <= '0;
            end else if (step) begin
                cnt  <= up ? cnt + 1'b1 : cnt - 1'b1;
                wrap <= bound;
            end
        end
    end

    // R10
    load_prio_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !load) |=> (cnt == '0));

    // R7
    wrap_val_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (($past(up) && cnt == '0) || (!$past(up) && (&cnt))));

endmodule

// File: rtl/tpr_timer_pair.sv
module tpr_timer_pair
    import tpr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [15:0]      wr_data,
    input  logic [1:0]       ext_clk,
    input  logic             evt_in,
    input  logic [1:0]       slot_tick,
    output logic [15:0]      ctl_lo_q,
    output logic [15:0]      ctl_hi_q,
    output logic [CNT_W-1:0] cnt_lo,
    output logic [CNT_W-1:0] cnt_hi,
    output logic             wrap_lo,
    output logic             wrap_hi
);

    tmr_ctl_t         ctl_r   [NTMR];
    logic [NTMR-1:0]  ctl_wr;
    logic [NTMR-1:0]  load;
    logic [NTMR-1:0]  own_step;
    logic [NTMR-1:0]  step_eff;
    logic [NTMR-1:0]  dir;
    logic [NTMR-1:0]  clr;
    logic [NTMR-1:0]  bound;
    logic [NTMR-1:0]  wrap_w;
    logic [CNT_W-1:0] cnt_w   [NTMR];
    logic             evt_prev;
    logic             evt_rise, evt_fall, clr_hi, chain;

    always_ff @(posedge clk) begin
        if (rst) evt_prev <= 1'b0;
        else     evt_prev <= evt_in;
    end

    assign evt_rise = evt_in & ~evt_prev;
    assign evt_fall = ~evt_in & evt_prev;
    assign clr_hi   = (ctl_r[1].evt_mode[0] & evt_fall) | (ctl_r[1].evt_mode[1] & evt_rise);
    assign chain    = ctl_r[1].chain;

    always_comb begin
        dir[0]      = ctl_r[0].up;
        step_eff[0] = own_step[0];
        clr[0]      = 1'b0;
        dir[1]      = chain ? ctl_r[0].up : ctl_r[1].up;
        step_eff[1] = chain ? (own_step[0] && !load[0] && bound[0] && ctl_r[1].en)
                            : own_step[1];
        clr[1]      = clr_hi;
    end

    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        assign ctl_wr[g] = wr_en && (wr_addr == 2'(g));
        assign load[g]   = wr_en && (wr_addr == 2'(g + 2));

        always_ff @(posedge clk) begin
            if (rst)            ctl_r[g] <= '0;
            else if (ctl_wr[g]) ctl_r[g] <= ctl_filter(wr_data, 1'(g == 1));
        end

        tpr_step_gen u_step (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl_r[g]),
            .ctl_wr (ctl_wr[g]),
            .pin    (ext_clk[g]),
            .slot   (slot_tick[g]),
            .step   (own_step[g])
        );

        tpr_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .load     (load[g]),
            .load_val (CNT_W'(wr_data)),
            .clr      (clr[g]),
            .step     (step_eff[g]),
            .up       (dir[g]),
            .cnt      (cnt_w[g]),
            .bound    (bound[g]),
            .wrap     (wrap_w[g])
        );
    end

    assign ctl_lo_q = ctl_r[0];
    assign ctl_hi_q = ctl_r[1];
    assign cnt_lo   = cnt_w[0];
    assign cnt_hi   = cnt_w[1];
    assign wrap_lo  = wrap_w[0];
    assign wrap_hi  = wrap_w[1];

    // R3
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_r[0].en && !load[0]) |=> $stable(cnt_w[0]));

    // R8
    chain_link_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(chain) && !$past(load[1]) && !$past(clr_hi) && cnt_w[1] != $past(cnt_w[1]))
        |-> wrap_w[0]);

endmodule

// File: tb/tpr_timer_pair_test.sv
`timescale 1ns/1ps
module tpr_timer_pair_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  ext_clk = 2'b00;
    logic        evt_in = 1'b0;
    logic [1:0]  slot_tick = 2'b00;
    logic [15:0] ctl_lo_q, ctl_hi_q, cnt_lo, cnt_hi;
    logic        wrap_lo, wrap_hi;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    bit done   = 0;

    // bench model state
    logic [15:0] m_ctl [2];
    logic [15:0] m_cnt [2];
    logic [5:0]  m_pre [2];
    logic        m_pend[2], m_s1[2], m_s2[2], m_s3[2], m_wrap[2];
    logic        m_evp;

    always #10 clk = ~clk;

    tpr_timer_pair #(.CNT_W(16)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ext_clk(ext_clk), .evt_in(evt_in), .slot_tick(slot_tick),
        .ctl_lo_q(ctl_lo_q), .ctl_hi_q(ctl_hi_q), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .wrap_lo(wrap_lo), .wrap_hi(wrap_hi)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, got %0d cycles exp done", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h exp %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [15:0] ctl_mask(input logic [15:0] d, input int idx);
        return d & ((idx == 1) ? 16'h03FF : 16'h031F);
    endfunction

    function automatic logic [5:0] pre_mask(input logic [2:0] code);
        if (code == 3'd7) return 6'd0;
        return 6'((7'd1 << code) - 7'd1);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_ctl[i] = 0; m_cnt[i] = 0; m_pre[i] = 0; m_pend[i] = 0;
            m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0; m_wrap[i] = 0;
        end
        m_evp = 0;
    endtask

    task automatic model_step();
        logic own[2], ld[2], cw[2];
        logic [5:0]  n_pre[2];
        logic        n_pend[2];
        logic        chain, up0, up1, b0, b1, st0, st1, clr, er, ef;
        for (int i = 0; i < 2; i++) begin
            logic [1:0] cm;
            logic en, rise, fall, edg, qual;
            logic [5:0] mk;
            cm   = m_ctl[i][4:3];
            en   = m_ctl[i][9];
            rise = m_s2[i] & ~m_s3[i];
            fall = ~m_s2[i] & m_s3[i];
            edg  = (cm == 2'b00) ? 1'b1 : (cm == 2'b01) ? fall : (cm == 2'b10) ? rise : (rise | fall);
            qual = en && slot_tick[i] && (m_pend[i] || edg);
            mk   = pre_mask(m_ctl[i][2:0]);
            own[i] = qual && ((m_pre[i] & mk) == mk);
            cw[i]  = wr_en && (wr_addr == 2'(i));
            ld[i]  = wr_en && (wr_addr == 2'(i + 2));
            n_pre[i]  = cw[i] ? 6'd0 : (qual ? m_pre[i] + 6'd1 : m_pre[i]);
            n_pend[i] = cw[i] ? 1'b0 : ((en && cm != 2'b00) ? ((m_pend[i] | edg) & ~slot_tick[i]) : 1'b0);
        end
        chain = m_ctl[1][7];
        up0   = m_ctl[0][8];
        up1   = chain ? up0 : m_ctl[1][8];
        b0    = up0 ? (m_cnt[0] == 16'hFFFF) : (m_cnt[0] == 16'h0000);
        b1    = up1 ? (m_cnt[1] == 16'hFFFF) : (m_cnt[1] == 16'h0000);
        st0   = own[0];
        st1   = chain ? (own[0] && !ld[0] && b0 && m_ctl[1][9]) : own[1];
        er    = evt_in & ~m_evp;
        ef    = ~evt_in & m_evp;
        clr   = (m_ctl[1][5] & ef) | (m_ctl[1][6] & er);
        m_wrap[0] = 0;
        m_wrap[1] = 0;
        if (ld[0]) m_cnt[0] = wr_data;
        else if (st0) begin
            m_wrap[0] = b0;
            m_cnt[0]  = up0 ? m_cnt[0] + 16'd1 : m_cnt[0] - 16'd1;
        end
        if (ld[1]) m_cnt[1] = wr_data;
        else if (clr) m_cnt[1] = 16'd0;
        else if (st1) begin
            m_wrap[1] = b1;
            m_cnt[1]  = up1 ? m_cnt[1] + 16'd1 : m_cnt[1] - 16'd1;
        end
        for (int i = 0; i < 2; i++) begin
            if (cw[i]) m_ctl[i] = ctl_mask(wr_data, i);
            m_pre[i]  = n_pre[i];
            m_pend[i] = n_pend[i];
            m_s3[i]   = m_s2[i];
            m_s2[i]   = m_s1[i];
            m_s1[i]   = ext_clk[i];
        end
        m_evp = evt_in;
    endtask

    task automatic tick(input string tag);
        model_step();
        @(posedge clk);
        #2;
        wr_en = 1'b0;
        chk(tag, "cnt_lo", cnt_lo, m_cnt[0]);
        chk(tag, "cnt_hi", cnt_hi, m_cnt[1]);
        chk(tag, "wrap_lo", 16'(wrap_lo), 16'(m_wrap[0]));
        chk(tag, "wrap_hi", 16'(wrap_hi), 16'(m_wrap[1]));
        chk(tag, "ctl_lo", ctl_lo_q, m_ctl[0]);
        chk(tag, "ctl_hi", ctl_hi_q, m_ctl[1]);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d, input string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(tag);
    endtask

    initial begin
        void'($urandom(32'h0051_7A3C));
        model_reset();
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R1 reset state
        chk("R1", "cnt_lo", cnt_lo, 16'h0);
        chk("R1", "cnt_hi", cnt_hi, 16'h0);
        chk("R1", "ctl_lo", ctl_lo_q, 16'h0);
        chk("R1", "ctl_hi", ctl_hi_q, 16'h0);
        chk("R1", "wraps", {14'd0, wrap_hi, wrap_lo}, 16'h0);

        // R2 reserved bits
        wr(2'd0, 16'hFFFF, "R2");
        wr(2'd1, 16'hFFFF, "R2");
        chk("R2", "ctl_lo_q", ctl_lo_q, 16'h031F);
        chk("R2", "ctl_hi_q", ctl_hi_q, 16'h03FF);
        wr(2'd0, 16'h0000, "R2");
        wr(2'd1, 16'h0000, "R2");
        wr(2'd2, 16'h0000, "R2");
        wr(2'd3, 16'h0000, "R2");

        // R4 up then down, R3 disable
        slot_tick = 2'b01;
        wr(2'd2, 16'd10, "R4");
        wr(2'd0, 16'h0300, "R4");
        repeat (5) tick("R4");
        chk("R4", "up count", cnt_lo, 16'd15);
        wr(2'd0, 16'h0200, "R4");
        repeat (3) tick("R4");
        chk("R4", "down count", cnt_lo, 16'd13);
        wr(2'd0, 16'h0000, "R3");
        repeat (4) tick("R3");
        chk("R3", "held", cnt_lo, 16'd12);

        // R5 prescaler
        wr(2'd0, 16'h0302, "R5");
        repeat (8) tick("R5");
        chk("R5", "div4", cnt_lo, 16'd14);
        wr(2'd0, 16'h0307, "R5");
        repeat (4) tick("R5");
        chk("R5", "code7", cnt_lo, 16'd18);

        // R10 write wins over counting
        wr(2'd2, 16'hABCD, "R10");
        chk("R10", "load prio", cnt_lo, 16'hABCD);
        wr(2'd0, 16'h0000, "R10");

        // R8 chained up, R7 wrap pulse
        wr(2'd2, 16'hFFFE, "R8");
        wr(2'd3, 16'h0005, "R8");
        wr(2'd1, 16'h0280, "R8");
        wr(2'd0, 16'h0300, "R8");
        tick("R8");
        chk("R8", "lo", cnt_lo, 16'hFFFF);
        tick("R8");
        chk("R8", "hi step", cnt_hi, 16'h0006);
        chk("R7", "wrap_lo", 16'(wrap_lo), 16'h1);
        tick("R7");
        chk("R7", "wrap_lo pulse", 16'(wrap_lo), 16'h0);
        wr(2'd0, 16'h0200, "R8");
        repeat (3) tick("R8");
        chk("R8", "down lo", cnt_lo, 16'hFFFF);
        chk("R8", "down hi", cnt_hi, 16'h0005);
        wr(2'd0, 16'h0000, "R8");
        wr(2'd1, 16'h0000, "R8");

        // R9 event clear
        slot_tick = 2'b00;
        wr(2'd1, 16'h0240, "R9");
        wr(2'd3, 16'h0077, "R9");
        evt_in = 1'b1; tick("R9");
        chk("R9", "rise clr", cnt_hi, 16'h0000);
        wr(2'd3, 16'h0077, "R9");
        evt_in = 1'b0; tick("R9");
        chk("R9", "fall ignored", cnt_hi, 16'h0077);
        wr(2'd1, 16'h0220, "R9");
        evt_in = 1'b1; tick("R9");
        chk("R9", "rise ignored", cnt_hi, 16'h0077);
        evt_in = 1'b0; tick("R9");
        chk("R9", "fall clr", cnt_hi, 16'h0000);
        wr(2'd1, 16'h0000, "R9");

        // R6 external edges
        slot_tick = 2'b01;
        wr(2'd2, 16'h0000, "R6");
        wr(2'd0, 16'h0310, "R6");
        ext_clk[0] = 1'b1;
        tick("R6"); tick("R6");
        chk("R6", "latency", cnt_lo, 16'd0);
        tick("R6");
        chk("R6", "rise", cnt_lo, 16'd1);
        ext_clk[0] = 1'b0;
        repeat (4) tick("R6");
        chk("R6", "fall ignored", cnt_lo, 16'd1);
        wr(2'd0, 16'h0318, "R6");
        ext_clk[0] = 1'b1; repeat (3) tick("R6");
        ext_clk[0] = 1'b0; repeat (3) tick("R6");
        chk("R6", "both", cnt_lo, 16'd3);
        slot_tick = 2'b00;
        ext_clk[0] = 1'b1; repeat (5) tick("R6");
        chk("R6", "no slot", cnt_lo, 16'd3);
        slot_tick = 2'b01; tick("R6");
        chk("R6", "pending", cnt_lo, 16'd4);

        // random mix, checked every cycle against the model
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 10 == 0) begin
                wr_en   = 1'b1;
                wr_addr = 2'($urandom % 4);
                if (wr_addr < 2'd2) begin
                    wr_data = 16'($urandom);
                    if ($urandom % 4 != 0) wr_data[9] = 1'b1;
                    if ($urandom % 3 == 0) wr_data[4:3] = 2'b00;
                end else begin
                    case ($urandom % 5)
                        0: wr_data = 16'h0000;
                        1: wr_data = 16'hFFFF;
                        2: wr_data = 16'hFFFD;
                        3: wr_data = 16'h0002;
                        default: wr_data = 16'($urandom);
                    endcase
                end
            end
            slot_tick = 2'($urandom % 4);
            if ($urandom % 3 == 0) ext_clk[0] = ~ext_clk[0];
            if ($urandom % 3 == 0) ext_clk[1] = ~ext_clk[1];
            if ($urandom % 6 == 0) evt_in = ~evt_in;
            tick("R7_R8_R5");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule